// File: doc/BRIEF.md
# Glitch Sentry Control Block

This block is the secure register front end for four voltage or clock glitch detectors. It sits on an APB bus and decides three things: whether the detectors are armed, which 2-bit sensitivity each detector runs at, and whether a trigger should restart the switched core power domain. The armed state comes from a fused arm default combined with two keyed software registers. One forces arming. The other cancels a fused arm.

A sensitivity override takes effect only behind a key byte. Each detector also has its own complement check. Triggers from the detectors are synchronized and collected in a sticky write-one-to-clear status register. Software can inject triggers through a self-clearing force register. While the block is armed, any real or injected trigger raises a domain reset request and sets a sticky glitch reset-reason flag.

A one-way lock freezes the configuration until reset. Only secure transactions reach the registers.

Top module: `gsentry_top`

## Requirements
- R1: After reset the force-arm register reads 0x5BAD, and the disarm, sensitivity, lock and status registers read 0. `armedOut` equals `otpArmDefault`, and `sensOut` equals `otpSensDefault`.
- R2: `armedOut` is high when the force-arm register (offset 0x00, bits 15:0) holds any value other than 0x5BAD. It is also high when `otpArmDefault` is high and the disarm register (offset 0x04, bits 15:0) holds any value other than 0xDCAF.
- R3: The sensitivity register is at offset 0x08. When its bits 31:24 equal 0xDE, detector N takes its sensitivity from bits [2N+1:2N], provided bits [2N+9:2N+8] are the bitwise inverse of that field. Otherwise detector N uses bits [2N+1:2N] of `otpSensDefault`. Bits 23:16 always read 0.
- R4: Writing a nonzero value to the 8-bit lock register (offset 0x0C) blocks every later write to the force-arm, disarm, sensitivity and lock registers until reset.
- R5: Bit N of the status register (offset 0x10, bits 3:0) is set by `detRaw[N]` after a two-flop synchronizer and stays set. A write with bit N high clears it. If the input is still high, the bit sets again at once.
- R6: Writing ones to the force register (offset 0x14, bits 3:0) sets the matching status bits. That register always reads 0.
- R7: One cycle after a cycle in which the block is armed and a synchronized or forced trigger is present, `domainResetReq` is high. `glitchResetFlag` then stays high until reset. While the block is disarmed, neither output changes.
- R8: An access with `pProt[1]` high reads 0, changes no register and asserts `pSlvErr`.
- R9: A read of an offset outside the six registers returns 0, and `pReady` is always high.
- R10: While the force-arm register holds a value other than 0x5BAD, the disarm register has no effect on `armedOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| pSel | input | 1 | APB select |
| pEnable | input | 1 | APB access phase |
| pWrite | input | 1 | APB write (1) or read (0) |
| pAddr | input | ADDR_W | APB byte address |
| pWdata | input | 32 | APB write data |
| pProt | input | 3 | APB protection; bit 1 high marks a non-secure access |
| pRdata | output | 32 | APB read data |
| pReady | output | 1 | APB ready, always high |
| pSlvErr | output | 1 | APB error for non-secure accesses |
| otpArmDefault | input | 1 | Fused arm default |
| otpSensDefault | input | NUM_DET*SENS_W | Fused per-detector sensitivity |
| detRaw | input | NUM_DET | Asynchronous detector trigger levels |
| sensOut | output | NUM_DET*SENS_W | Sensitivity applied to each detector |
| armedOut | output | 1 | Detectors armed |
| domainResetReq | output | 1 | Request to restart the switched core domain |
| glitchResetFlag | output | 1 | Sticky glitch reset-reason flag |

## Verification
The assertions assume that `pSel`, `pEnable`, `pProt` and `pWrite` follow the APB two-phase protocol. They also assume that `detRaw` and the fused defaults stay quiet during reset. The stimulus drives every bus signal on the falling clock edge and always completes the setup and access phases in order.

The fused inputs change only between transfers. The trigger inputs are held for several cycles, so each level passes through the synchronizer before it is observed.

// File: rtl/gsentry_pkg.sv
package gsentry_pkg;

  localparam logic [15:0] ARM_IDLE_KEY  = 16'h5BAD;
  localparam logic [15:0] DISARM_KEY    = 16'hDCAF;
  localparam logic [7:0]  SENS_OWN_KEY  = 8'hDE;

  localparam int OFS_ARM    = 'h00;
  localparam int OFS_DISARM = 'h04;
  localparam int OFS_SENS   = 'h08;
  localparam int OFS_LOCK   = 'h0C;
  localparam int OFS_STATUS = 'h10;
  localparam int OFS_FORCE  = 'h14;

  typedef enum logic [2:0] {
    SEL_ARM, SEL_DISARM, SEL_SENS, SEL_LOCK, SEL_STATUS, SEL_FORCE, SEL_NONE
  } regSel_e;

  typedef struct packed {
    logic    wrArm;
    logic    wrDisarm;
    logic    wrSens;
    logic    wrLock;
    logic    wrClear;
    logic    wrForce;
    logic    rdEn;
    regSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/gsentry_sync.sv
module gsentry_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) stageQ[0] <= '0;
    else       stageQ[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stageQ[s] <= '0;
      else       stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/gsentry_ctrl.sv
module gsentry_ctrl
  import gsentry_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic [ADDR_W-1:0] pAddr,
  input  logic [2:0]        pProt,
  input  logic              locked,
  output strobe_t           stb,
  output logic              pSlvErr
);
  logic    access, secure, allowed, wrOk;
  regSel_e sel;

  assign access  = pSel & pEnable;
  assign secure  = ~pProt[1];
  assign allowed = access & secure;
  assign wrOk    = allowed & pWrite;

  always_comb begin
    sel = SEL_NONE;
    if      (pAddr == ADDR_W'(OFS_ARM))    sel = SEL_ARM;
    else if (pAddr == ADDR_W'(OFS_DISARM)) sel = SEL_DISARM;
    else if (pAddr == ADDR_W'(OFS_SENS))   sel = SEL_SENS;
    else if (pAddr == ADDR_W'(OFS_LOCK))   sel = SEL_LOCK;
    else if (pAddr == ADDR_W'(OFS_STATUS)) sel = SEL_STATUS;
    else if (pAddr == ADDR_W'(OFS_FORCE))  sel = SEL_FORCE;
  end

  always_comb begin
    stb.wrArm    = wrOk & ~locked & (sel == SEL_ARM);
    stb.wrDisarm = wrOk & ~locked & (sel == SEL_DISARM);
    stb.wrSens   = wrOk & ~locked & (sel == SEL_SENS);
    stb.wrLock   = wrOk & ~locked & (sel == SEL_LOCK);
    stb.wrClear  = wrOk & (sel == SEL_STATUS);
    stb.wrForce  = wrOk & (sel == SEL_FORCE);
    stb.rdEn     = allowed & ~pWrite;
    stb.rdSel    = sel;
  end

  assign pSlvErr = access & ~secure;
endmodule

// File: rtl/gsentry_core.sv
module gsentry_core
  import gsentry_pkg::*;
#(
  parameter int NUM_DET     = 4,
  parameter int SENS_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  input  logic [31:0]               wdata,
  input  logic                      otpArm,
  input  logic [NUM_DET*SENS_W-1:0] otpSens,
  input  logic [NUM_DET-1:0]        detRaw,
  output logic [31:0]               rdata,
  output logic                      locked,
  output logic                      armed,
  output logic [NUM_DET*SENS_W-1:0] sensOut,
  output logic                      resetReq,
  output logic                      resetFlag
);
  localparam int FIELD_W = NUM_DET * SENS_W;
  localparam int CHK_LSB = 8;
  localparam int KEY_LSB = 24;
  localparam logic [31:0] FIELD_ONES = (32'h1 << FIELD_W) - 32'h1;
  localparam logic [31:0] SENS_MASK  = (32'hFF << KEY_LSB)
                                     | (FIELD_ONES << CHK_LSB) | FIELD_ONES;

  logic [15:0]        armQ, disarmQ;
  logic [31:0]        sensQ;
  logic [7:0]         lockQ;
  logic [NUM_DET-1:0] statusQ, detSync, forceBits, clearBits, trigNow;
  logic               resetReqQ, resetFlagQ, fire;

  gsentry_sync #(.WIDTH(NUM_DET), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(detRaw), .syncOut(detSync)
  );

  assign forceBits = stb.wrForce ? wdata[NUM_DET-1:0] : '0;
  assign clearBits = stb.wrClear ? wdata[NUM_DET-1:0] : '0;
  assign trigNow   = detSync | forceBits;
  assign armed     = (armQ != ARM_IDLE_KEY) | (otpArm & (disarmQ != DISARM_KEY));
  assign fire      = armed & (|trigNow);
  assign locked    = |lockQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armQ       <= ARM_IDLE_KEY;
      disarmQ    <= '0;
      sensQ      <= '0;
      lockQ      <= '0;
      statusQ    <= '0;
      resetReqQ  <= 1'b0;
      resetFlagQ <= 1'b0;
    end else begin
      if (stb.wrArm)    armQ    <= wdata[15:0];
      if (stb.wrDisarm) disarmQ <= wdata[15:0];
      if (stb.wrSens)   sensQ   <= wdata & SENS_MASK;
      if (stb.wrLock)   lockQ   <= wdata[7:0];
      statusQ    <= (statusQ & ~clearBits) | trigNow;
      resetReqQ  <= fire;
      resetFlagQ <= resetFlagQ | fire;
    end
  end

  logic useOwn;
  assign useOwn = (sensQ[KEY_LSB +: 8] == SENS_OWN_KEY);

  for (genvar n = 0; n < NUM_DET; n++) begin : g_det
    logic [SENS_W-1:0] ownVal, chkVal;
    assign ownVal = sensQ[n*SENS_W +: SENS_W];
    assign chkVal = sensQ[CHK_LSB + n*SENS_W +: SENS_W];
    assign sensOut[n*SENS_W +: SENS_W] =
      (useOwn && (chkVal == ~ownVal)) ? ownVal : otpSens[n*SENS_W +: SENS_W];
  end

  always_comb begin
    rdata = '0;
    if (stb.rdEn) begin
      case (stb.rdSel)
        SEL_ARM:    rdata = {16'h0, armQ};
        SEL_DISARM: rdata = {16'h0, disarmQ};
        SEL_SENS:   rdata = sensQ;
        SEL_LOCK:   rdata = {24'h0, lockQ};
        SEL_STATUS: rdata = {{(32-NUM_DET){1'b0}}, statusQ};
        default:    rdata = '0;
      endcase
    end
  end

  assign resetReq  = resetReqQ;
  assign resetFlag = resetFlagQ;
endmodule

// File: rtl/gsentry_top.sv
module gsentry_top
  import gsentry_pkg::*;
#(
  parameter int NUM_DET = 4,
  parameter int SENS_W  = 2,
  parameter int ADDR_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      pSel,
  input  logic                      pEnable,
  input  logic                      pWrite,
  input  logic [ADDR_W-1:0]         pAddr,
  input  logic [31:0]               pWdata,
  input  logic [2:0]                pProt,
  output logic [31:0]               pRdata,
  output logic                      pReady,
  output logic                      pSlvErr,
  input  logic                      otpArmDefault,
  input  logic [NUM_DET*SENS_W-1:0] otpSensDefault,
  input  logic [NUM_DET-1:0]        detRaw,
  output logic [NUM_DET*SENS_W-1:0] sensOut,
  output logic                      armedOut,
  output logic                      domainResetReq,
  output logic                      glitchResetFlag
);
  strobe_t stb;
  logic    locked;

  gsentry_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite), .pAddr(pAddr),
    .pProt(pProt), .locked(locked), .stb(stb), .pSlvErr(pSlvErr)
  );

  gsentry_core #(.NUM_DET(NUM_DET), .SENS_W(SENS_W), .SYNC_STAGES(2)) u_core (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(pWdata),
    .otpArm(otpArmDefault), .otpSens(otpSensDefault), .detRaw(detRaw),
    .rdata(pRdata), .locked(locked), .armed(armedOut), .sensOut(sensOut),
    .resetReq(domainResetReq), .resetFlag(glitchResetFlag)
  );

  assign pReady = 1'b1;
endmodule

// File: rtl/gsentry_chk.sv
module gsentry_chk (
  input logic        clk,
  input logic        rstN,
  input logic        pSel,
  input logic        pEnable,
  input logic [2:0]  pProt,
  input logic        pSlvErr,
  input logic [31:0] pRdata,
  input logic        armedOut,
  input logic        domainResetReq,
  input logic        glitchResetFlag,
  input logic        locked
);
  // R8
  nonsecure_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && pEnable && pProt[1]) |-> (pSlvErr && pRdata == 32'h0));

  // R7
  req_needs_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    domainResetReq |-> $past(armedOut));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    glitchResetFlag |=> glitchResetFlag);

  // R7
  req_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    domainResetReq |-> glitchResetFlag);

  // R4
  lock_oneway_chk: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);
endmodule

bind gsentry_top gsentry_chk u_chk (
  .clk(clk), .rstN(rstN), .pSel(pSel), .pEnable(pEnable), .pProt(pProt),
  .pSlvErr(pSlvErr), .pRdata(pRdata), .armedOut(armedOut),
  .domainResetReq(domainResetReq), .glitchResetFlag(glitchResetFlag),
  .locked(locked)
);

// File: tb/gsentry_top_tb.sv
`timescale 1ns/100ps
module gsentry_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pSel = 1'b0, pEnable = 1'b0, pWrite = 1'b0;
  logic [7:0]  pAddr = '0;
  logic [31:0] pWdata = '0;
  logic [2:0]  pProt = '0;
  logic [31:0] pRdata;
  logic        pReady, pSlvErr;
  logic        otpArmDefault = 1'b0;
  logic [7:0]  otpSensDefault = 8'h6C;
  logic [3:0]  detRaw = '0;
  logic [7:0]  sensOut;
  logic        armedOut, domainResetReq, glitchResetFlag;

  int checks = 0;
  int failures = 0;
  logic [32:0] expQ[$];
  string       tagQ[$];
  event        sampleEv;

  always #2.5 clk = ~clk;

  gsentry_top u_dut (
    .clk(clk), .rstN(rstN), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite),
    .pAddr(pAddr), .pWdata(pWdata), .pProt(pProt), .pRdata(pRdata),
    .pReady(pReady), .pSlvErr(pSlvErr), .otpArmDefault(otpArmDefault),
    .otpSensDefault(otpSensDefault), .detRaw(detRaw), .sensOut(sensOut),
    .armedOut(armedOut), .domainResetReq(domainResetReq),
    .glitchResetFlag(glitchResetFlag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [7:0] a, input logic [31:0] d, input logic ns);
    @(negedge clk);
    pSel = 1'b1; pEnable = 1'b0; pWrite = 1'b1; pAddr = a; pWdata = d;
    pProt = ns ? 3'b010 : 3'b000;
    @(negedge clk);
    pEnable = 1'b1;
    @(negedge clk);
    pSel = 1'b0; pEnable = 1'b0; pWrite = 1'b0; pProt = 3'b000;
  endtask

  // driver: pushes the expected read item, the monitor pops it
  task automatic apbRead(input logic [7:0] a, input logic [31:0] exp,
                         input logic ns, input string tag);
    expQ.push_back({ns, exp});
    tagQ.push_back(tag);
    @(negedge clk);
    pSel = 1'b1; pEnable = 1'b0; pWrite = 1'b0; pAddr = a;
    pProt = ns ? 3'b010 : 3'b000;
    @(negedge clk);
    pEnable = 1'b1;
    #1 -> sampleEv;
    @(negedge clk);
    pSel = 1'b0; pEnable = 1'b0; pProt = 3'b000;
  endtask

  always @(sampleEv) begin
    logic [32:0] e;
    string t;
    e = expQ.pop_front();
    t = tagQ.pop_front();
    checks++;
    if (pRdata !== e[31:0] || pSlvErr !== e[32] || pReady !== 1'b1) begin
      failures++;
      $display("FAIL %s actual=%h/err%0b expected=%h/err%0b", t, pRdata, pSlvErr, e[31:0], e[32]);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    apbRead(8'h00, 32'h5BAD, 1'b0, "R1 arm");
    apbRead(8'h04, 32'h0, 1'b0, "R1 disarm");
    apbRead(8'h08, 32'h0, 1'b0, "R1 sens");
    apbRead(8'h0C, 32'h0, 1'b0, "R1 lock");
    apbRead(8'h10, 32'h0, 1'b0, "R1 status");
    chk("R1 armed", {31'h0, armedOut}, 32'h0);
    chk("R1 sensOut", {24'h0, sensOut}, 32'h6C);
    chk("R1 req", {31'h0, domainResetReq}, 32'h0);
    // R9 unmapped, R6 force reads zero
    apbRead(8'h18, 32'h0, 1'b0, "R9 unmapped");
    apbRead(8'h14, 32'h0, 1'b0, "R6 force read");
    // R2 arm logic
    otpArmDefault = 1'b1;
    @(negedge clk);
    chk("R2 otp armed", {31'h0, armedOut}, 32'h1);
    apbWrite(8'h04, 32'hDCAF, 1'b0);
    chk("R2 disarmed", {31'h0, armedOut}, 32'h0);
    apbRead(8'h04, 32'hDCAF, 1'b0, "R2 disarm readback");
    apbWrite(8'h04, 32'h1234, 1'b0);
    chk("R2 wrong key", {31'h0, armedOut}, 32'h1);
    apbWrite(8'h04, 32'hDCAF, 1'b0);
    // R10 force-arm overrides disarm
    apbWrite(8'h00, 32'h0000, 1'b0);
    chk("R10 forced arm", {31'h0, armedOut}, 32'h1);
    apbWrite(8'h00, 32'h5BAD, 1'b0);
    chk("R10 release", {31'h0, armedOut}, 32'h0);
    // R3 sensitivity selection
    apbWrite(8'h08, 32'hDEFFDC27, 1'b0);
    chk("R3 own values", {24'h0, sensOut}, 32'h2F);
    apbRead(8'h08, 32'hDE00DC27, 1'b0, "R3 readback");
    apbWrite(8'h08, 32'hDF00DC27, 1'b0);
    chk("R3 wrong key", {24'h0, sensOut}, 32'h6C);
    // R6 force while disarmed, R7 no request
    apbWrite(8'h14, 32'h5, 1'b0);
    chk("R7 no req disarmed", {31'h0, domainResetReq}, 32'h0);
    apbRead(8'h10, 32'h5, 1'b0, "R6 forced status");
    chk("R7 no flag", {31'h0, glitchResetFlag}, 32'h0);
    // R5 write one to clear
    apbWrite(8'h10, 32'h1, 1'b0);
    apbRead(8'h10, 32'h4, 1'b0, "R5 clear bit0");
    apbWrite(8'h10, 32'h4, 1'b0);
    apbRead(8'h10, 32'h0, 1'b0, "R5 clear bit2");
    // R5 synchronized raw trigger, held level resets bit
    detRaw = 4'b0100;
    repeat (4) @(negedge clk);
    apbRead(8'h10, 32'h4, 1'b0, "R5 raw sets");
    apbWrite(8'h10, 32'h4, 1'b0);
    apbRead(8'h10, 32'h4, 1'b0, "R5 held resets");
    detRaw = 4'b0000;
    repeat (4) @(negedge clk);
    apbWrite(8'h10, 32'hF, 1'b0);
    apbRead(8'h10, 32'h0, 1'b0, "R5 released clears");
    // R7 armed force
    apbWrite(8'h04, 32'h0, 1'b0);
    chk("R7 armed", {31'h0, armedOut}, 32'h1);
    apbWrite(8'h14, 32'h2, 1'b0);
    chk("R7 req after force", {31'h0, domainResetReq}, 32'h1);
    chk("R7 flag set", {31'h0, glitchResetFlag}, 32'h1);
    @(negedge clk);
    chk("R7 req drops", {31'h0, domainResetReq}, 32'h0);
    chk("R7 flag stays", {31'h0, glitchResetFlag}, 32'h1);
    detRaw = 4'b0001;
    repeat (5) @(negedge clk);
    chk("R7 req from raw", {31'h0, domainResetReq}, 32'h1);
    detRaw = 4'b0000;
    repeat (4) @(negedge clk);
    chk("R7 req idle", {31'h0, domainResetReq}, 32'h0);
    // R8 non-secure
    apbWrite(8'h00, 32'h0000, 1'b1);
    apbRead(8'h00, 32'h5BAD, 1'b0, "R8 write ignored");
    apbRead(8'h00, 32'h0, 1'b1, "R8 read zero err");
    // R4 lock
    apbWrite(8'h0C, 32'h1, 1'b0);
    apbRead(8'h0C, 32'h1, 1'b0, "R4 lock set");
    apbWrite(8'h00, 32'h0000, 1'b0);
    apbRead(8'h00, 32'h5BAD, 1'b0, "R4 arm blocked");
    apbWrite(8'h08, 32'hDE00DC27, 1'b0);
    chk("R4 sens blocked", {24'h0, sensOut}, 32'h6C);
    apbWrite(8'h0C, 32'h0, 1'b0);
    apbRead(8'h0C, 32'h1, 1'b0, "R4 lock oneway");
    apbWrite(8'h10, 32'hF, 1'b0);
    apbRead(8'h10, 32'h0, 1'b0, "R5 clear under lock");
    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule